// File: doc/BRIEF.md
# Asynchronous Memory Access Phase Sequencer

This block times a single read or write to an external asynchronous static memory or NOR device. A requester hands over an access on a valid/ready request port: a read/write flag, an address, write data and a packed timing word. The block then steps through its phases, counting one kernel-clock cycle per step: address setup, an optional address hold, the data phase, data hold and bus turnaround. From the current phase it decodes the memory strobes, and it captures the read data from the memory bus.

The request port obeys valid/ready rules. `req_ready` is high only while the sequencer is idle. An access is taken on a rising clock edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low must keep `req_valid` and its payload steady until the transfer happens. Only one access is in flight at a time, so back-pressure lasts from the accepting edge to the end of turnaround. All memory-side strobes are active high.

The timing word holds these fields: setup length in bits [3:0], address-hold length in [7:4], data length in [15:8], turnaround field in [19:16], data-hold field in [21:20], and the address-hold enable in bit 22.

Top module: `async_access_seq`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress. An access is accepted on an edge with `req_valid` and `req_ready` both high. During an access `req_ready` stays low and the request port has no effect.
- R2: After the accepting edge, address setup runs for cfg[3:0] cycles. A value of 0 skips the phase. During setup `mem_cs` and `mem_addr_valid` are high and `mem_oe`/`mem_we` are low.
- R3: The address-hold phase follows setup only when cfg[22] is 1. It lasts cfg[7:4] cycles, and a field of 0 counts as 1. When cfg[22] is 0 the phase is absent.
- R4: The data phase lasts cfg[15:8] cycles, and a field of 0 counts as 1. In this phase `mem_oe` is high for a read and `mem_we` is high for a write.
- R5: The data-hold phase lasts cfg[21:20] cycles for a read (0 skips it) and cfg[21:20]+1 cycles for a write. `mem_cs` and `mem_addr_valid` stay high through it, and `mem_oe`/`mem_we` are low.
- R6: Turnaround lasts cfg[19:16]+1 cycles with `mem_cs` low. `done` is high for exactly its last cycle, and the block is idle on the next cycle.
- R7: On a read, `rd_data` takes the value of `mem_rdata_in` at the clock edge that ends the last data cycle, and then holds it. A write leaves `rd_data` unchanged.
- R8: `mem_addr` shows the accepted address whenever `mem_cs` is high. On a write, `mem_drive` is high during the data and data-hold phases, and `mem_wdata` shows the accepted write data. On a read, `mem_drive` stays low.
- R9: The timing word, address, data and read/write flag are sampled at acceptance. Changes to them during an access do not alter its phases or outputs.
- R10: After reset the block is idle: `req_ready` is 1, all strobes and `done` are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_cfg | input | 23 | Packed timing word |
| mem_cs | output | 1 | Chip select |
| mem_oe | output | 1 | Output enable (read strobe) |
| mem_we | output | 1 | Write enable (write strobe) |
| mem_addr_valid | output | 1 | Address presented on the bus |
| mem_addr | output | ADDR_W | Latched address |
| mem_wdata | output | DATA_W | Latched write data |
| mem_drive | output | 1 | Data bus drive enable |
| mem_rdata_in | input | DATA_W | Data bus from the memory |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The hardest case to reach from the ports is a chain of phases in which several lengths are zero or at their odd rules at the same time. Examples are a zero setup with address hold enabled and a zero hold field, or a zero data field followed by a read with no data hold. In such chains the phase skipping has to land on the correct next phase in one step. Directed accesses build these chains explicitly, and randomly drawn timing words cover other combinations. Each access is traced cycle by cycle against a bench-computed schedule. After acceptance, the bench scrambles the request inputs so that any use of unsampled values shows up in the trace.

// File: rtl/async_seq_pkg.sv
package async_seq_pkg;

  localparam int CFG_W = 23;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_AHOLD = 3'd2,
    PH_DATA  = 3'd3,
    PH_DHOLD = 3'd4,
    PH_TURN  = 3'd5
  } phase_e;

  // bit 22: hold enable, [21:20] data hold, [19:16] turnaround,
  // [15:8] data, [7:4] address hold, [3:0] setup
  typedef struct packed {
    logic       hold_en;
    logic [1:0] dhold;
    logic [3:0] turn;
    logic [7:0] data;
    logic [3:0] ahold;
    logic [3:0] setup;
  } timing_cfg_t;

  localparam timing_cfg_t CFG_RESET = '{
    hold_en: 1'b0, dhold: 2'd0, turn: 4'hF,
    data: 8'hFF, ahold: 4'hF, setup: 4'hF
  };

endpackage

// File: rtl/phase_lengths.sv
module phase_lengths
  import async_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  timing_cfg_t      cfg,
  input  logic             is_write,
  output logic [CNT_W-1:0] len_setup,
  output logic [CNT_W-1:0] len_ahold,
  output logic [CNT_W-1:0] len_data,
  output logic [CNT_W-1:0] len_dhold,
  output logic [CNT_W-1:0] len_turn
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    len_setup = CNT_W'(cfg.setup);
    if (!cfg.hold_en)
      len_ahold = '0;
    else if (cfg.ahold == 4'd0)
      len_ahold = ONE;
    else
      len_ahold = CNT_W'(cfg.ahold);
    len_data  = (cfg.data == 8'd0) ? ONE : CNT_W'(cfg.data);
    len_dhold = is_write ? CNT_W'(cfg.dhold) + ONE : CNT_W'(cfg.dhold);
    len_turn  = CNT_W'(cfg.turn) + ONE;
  end

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import async_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] st_setup,
  input  logic [CNT_W-1:0] st_ahold,
  input  logic [CNT_W-1:0] st_data,
  input  logic [CNT_W-1:0] run_ahold,
  input  logic [CNT_W-1:0] run_data,
  input  logic [CNT_W-1:0] run_dhold,
  input  logic [CNT_W-1:0] run_turn,
  output phase_e           phase,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  phase_e           nxt_phase;
  logic [CNT_W-1:0] nxt_cnt;

  assign last = (phase != PH_IDLE) && (cnt_q == CNT_W'(1));

  always_comb begin
    nxt_phase = phase;
    nxt_cnt   = cnt_q - CNT_W'(1);
    unique case (phase)
      PH_IDLE: begin
        nxt_cnt = cnt_q;
        if (start) begin
          if (st_setup != '0) begin
            nxt_phase = PH_SETUP; nxt_cnt = st_setup;
          end else if (st_ahold != '0) begin
            nxt_phase = PH_AHOLD; nxt_cnt = st_ahold;
          end else begin
            nxt_phase = PH_DATA;  nxt_cnt = st_data;
          end
        end
      end
      PH_SETUP: if (last) begin
        if (run_ahold != '0) begin
          nxt_phase = PH_AHOLD; nxt_cnt = run_ahold;
        end else begin
          nxt_phase = PH_DATA;  nxt_cnt = run_data;
        end
      end
      PH_AHOLD: if (last) begin
        nxt_phase = PH_DATA; nxt_cnt = run_data;
      end
      PH_DATA: if (last) begin
        if (run_dhold != '0) begin
          nxt_phase = PH_DHOLD; nxt_cnt = run_dhold;
        end else begin
          nxt_phase = PH_TURN;  nxt_cnt = run_turn;
        end
      end
      PH_DHOLD: if (last) begin
        nxt_phase = PH_TURN; nxt_cnt = run_turn;
      end
      PH_TURN: if (last) begin
        nxt_phase = PH_IDLE; nxt_cnt = '0;
      end
      default: begin
        nxt_phase = PH_IDLE; nxt_cnt = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      phase <= nxt_phase;
      cnt_q <= nxt_cnt;
    end
  end

  // R1: without a start the sequencer stays idle
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));

  // R6: the end of turnaround returns to idle
  a_r6_turn_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN && last) |=> (phase == PH_IDLE));

  // R4: data phase is always followed by data hold or turnaround
  a_r4_data_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && last) |=> (phase == PH_DHOLD || phase == PH_TURN));

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import async_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              last,
  input  logic              is_write,
  input  logic [DATA_W-1:0] bus_in,
  output logic              cs,
  output logic              oe,
  output logic              we,
  output logic              addr_valid,
  output logic              drive,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);

  logic in_access, in_data;

  assign in_access  = (phase == PH_SETUP) || (phase == PH_AHOLD) ||
                      (phase == PH_DATA)  || (phase == PH_DHOLD);
  assign in_data    = (phase == PH_DATA);
  assign cs         = in_access;
  assign addr_valid = in_access;
  assign oe         = in_data && !is_write;
  assign we         = in_data && is_write;
  assign drive      = is_write && (in_data || phase == PH_DHOLD);
  assign done       = (phase == PH_TURN) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (in_data && last && !is_write)
      rd_data <= bus_in;
  end

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a write strobe always comes with the bus driven
  a_r8_we_drives: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> drive);

  // R7: read data changes only on a read's last data cycle
  a_r7_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_data && last && !is_write) |=> $stable(rd_data));

endmodule

// File: rtl/async_access_seq.sv
module async_access_seq
  import async_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [CFG_W-1:0]      req_cfg,
  output logic                  mem_cs,
  output logic                  mem_oe,
  output logic                  mem_we,
  output logic                  mem_addr_valid,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  mem_drive,
  input  logic [DATA_W-1:0]     mem_rdata_in,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  done
);

  localparam int CNT_W = 8;

  phase_e      phase;
  logic        last;
  logic        accept;
  timing_cfg_t cfg_q, cfg_in;
  logic        write_q;

  logic [CNT_W-1:0] st_setup, st_ahold, st_data, st_dhold, st_turn;
  logic [CNT_W-1:0] rn_setup, rn_ahold, rn_data, rn_dhold, rn_turn;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign cfg_in    = timing_cfg_t'(req_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RESET;
      write_q   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (accept) begin
      cfg_q     <= cfg_in;
      write_q   <= req_write;
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
    end
  end

  // lengths for launching from the incoming word
  phase_lengths #(.CNT_W(CNT_W)) u_len_start (
    .cfg(cfg_in), .is_write(req_write),
    .len_setup(st_setup), .len_ahold(st_ahold), .len_data(st_data),
    .len_dhold(st_dhold), .len_turn(st_turn)
  );

  // lengths for the running access from the sampled word
  phase_lengths #(.CNT_W(CNT_W)) u_len_run (
    .cfg(cfg_q), .is_write(write_q),
    .len_setup(rn_setup), .len_ahold(rn_ahold), .len_data(rn_data),
    .len_dhold(rn_dhold), .len_turn(rn_turn)
  );

  phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .st_setup(st_setup), .st_ahold(st_ahold), .st_data(st_data),
    .run_ahold(rn_ahold), .run_data(rn_data),
    .run_dhold(rn_dhold), .run_turn(rn_turn),
    .phase(phase), .last(last)
  );

  strobe_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last),
    .is_write(write_q), .bus_in(mem_rdata_in),
    .cs(mem_cs), .oe(mem_oe), .we(mem_we), .addr_valid(mem_addr_valid),
    .drive(mem_drive), .done(done), .rd_data(rd_data)
  );

  // R9: sampled timing word is frozen while busy
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(cfg_q));

  // R1: chip select is never active while ready
  a_r1_cs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> !req_ready);

  // R8: a read never drives the data bus
  a_r8_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |-> !mem_drive);

endmodule

// File: tb/tb_async_access_seq.sv
module tb_async_access_seq;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [22:0]       req_cfg = '0;
  logic              mem_cs, mem_oe, mem_we, mem_addr_valid, mem_drive, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata_in = '0;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] last_rd = '0;

  always #5 clk = ~clk;

  async_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  function automatic logic [DATA_W-1:0] bus_pat(int k, int base);
    return DATA_W'(k * 37 + base);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [22:0] cfg, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd);
    int s, ah, d, h, t, b1, b2, b3, b4, b5, base;
    logic [6:0] got, exp;
    bit trace_ok;
    string tag;
    s  = int'(cfg[3:0]);
    ah = cfg[22] ? ((cfg[7:4] == 0) ? 1 : int'(cfg[7:4])) : 0;
    d  = (cfg[15:8] == 0) ? 1 : int'(cfg[15:8]);
    h  = wr ? int'(cfg[21:20]) + 1 : int'(cfg[21:20]);
    t  = int'(cfg[19:16]) + 1;
    b1 = s; b2 = b1 + ah; b3 = b2 + d; b4 = b3 + h; b5 = b4 + t;
    base = int'($urandom % 1000);
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_cfg = cfg; req_addr = a; req_wdata = wd;
    @(negedge clk);
    // R9: scramble the request port after acceptance
    req_valid = 1'b0; req_write = ~wr; req_cfg = 23'($urandom);
    req_addr = ADDR_W'($urandom); req_wdata = DATA_W'($urandom);
    trace_ok = 1'b1;
    for (int k = 1; k <= b5; k++) begin
      exp = {1'b0, k <= b4, k <= b4, !wr && k > b2 && k <= b3,
             wr && k > b2 && k <= b3, wr && k > b2 && k <= b4, k == b5};
      got = {req_ready, mem_cs, mem_addr_valid, mem_oe, mem_we, mem_drive, done};
      if (k <= b1) tag = "R2"; else if (k <= b2) tag = "R3";
      else if (k <= b3) tag = "R4"; else if (k <= b4) tag = "R5"; else tag = "R6";
      if (got !== exp && trace_ok) begin
        chk(1'b0, tag, $sformatf("strobes cycle %0d", k), 64'(got), 64'(exp));
        trace_ok = 1'b0;
      end
      if (k <= b4 && trace_ok) begin
        if (mem_addr !== a || (wr && mem_wdata !== wd)) begin
          chk(1'b0, "R8", "address/data held", 64'(mem_addr), 64'(a));
          trace_ok = 1'b0;
        end
      end
      mem_rdata_in = bus_pat(k, base);
      @(negedge clk);
    end
    if (trace_ok) chk(1'b1, "R9", "trace", 0, 0);
    if (!wr) last_rd = bus_pat(b3, base);
    chk(rd_data === last_rd, "R7", "read data", 64'(rd_data), 64'(last_rd));
    chk(req_ready === 1'b1 && mem_cs === 1'b0 && done === 1'b0, "R6",
        "idle after turnaround", 64'({req_ready, mem_cs, done}), 64'b100);
  endtask

  function automatic logic [22:0] mk(bit he, int dh, int tu, int da, int ah, int su);
    return {he, 2'(dh), 4'(tu), 8'(da), 4'(ah), 4'(su)};
  endfunction

  initial begin
    void'($urandom(32'h5eed_0001));
    #1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "ready in reset", 64'(req_ready), 64'd1);
    chk({mem_cs, mem_oe, mem_we, mem_addr_valid, mem_drive, done} === 6'b0, "R10",
        "strobes in reset", 64'({mem_cs, mem_oe, mem_we, mem_addr_valid, mem_drive, done}), 0);
    chk(rd_data === '0, "R10", "read data in reset", 64'(rd_data), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    access(1'b0, mk(0, 0, 0, 0, 0, 0), 24'h000001, 16'h0);     // R2 skip, R4 zero->1, R5 none
    access(1'b1, mk(0, 0, 0, 0, 0, 0), 24'h000002, 16'hA5A5);  // R5 write min 1
    access(1'b0, mk(1, 3, 15, 2, 0, 0), 24'h000003, 16'h0);    // R3 zero hold ->1
    access(1'b1, mk(1, 3, 7, 5, 9, 4), 24'h0ABCDE, 16'h1234);  // R3, R5 write 4
    access(1'b0, mk(0, 2, 15, 255, 15, 15), 24'hFFFFFF, 16'h0); // long maxima
    access(1'b1, mk(0, 1, 3, 1, 6, 1), 24'h123456, 16'hBEEF);  // R7 write keeps rd
    // random mix
    for (int i = 0; i < 40; i++) begin
      access(1'($urandom), mk(1'($urandom), int'($urandom % 4), int'($urandom % 16),
             int'($urandom % 20), int'($urandom % 16), int'($urandom % 16)),
             ADDR_W'($urandom), DATA_W'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule